// File: doc/BRIEF.md
# Single-Precision Round and Pack Unit

This block takes the unpacked result of a floating-point operation (a sign, a signed unbiased exponent and a wide significand) and turns it into a 32-bit single-precision word. The significand is an exact value whose low bits act as guard and sticky bits. The block normalizes the significand, places the exponent in biased form and rounds the value under one of four rounding modes. Depending on magnitude, it delivers a normal number, a subnormal number, a signed zero, infinity or the largest finite value. It also sets overflow, underflow and inexact flags. The invalid and divide-by-zero flags come from the arithmetic stage and pass through without change.

Underflow is gradual by default: tiny results become correctly rounded subnormals. When the flush input is set, any tiny nonzero result becomes a zero of the same sign instead. A valid/ready handshake with a single output register carries each result.

The input significand `in_sig` has `SIG_W` bits, and its binary point sits just right of the top bit. The value presented is therefore `in_sig / 2^(SIG_W-1) * 2^in_exp`. With the default `SIG_W = 28`, `in_sig = 28'h8000000` and `in_exp = 0` mean 1.0.

Top module: `binary32_round_pack`

## Requirements
- R1: The output word carries the sign in bit 31, the biased exponent (bias 127) in bits 30:23 and the fraction in bits 22:0. A significand with leading zeros is normalized first, so 1.0 given as `{exp 0, sig 8000000h}` or as `{exp 1, sig 4000000h}` packs to 3F800000h.
- R2: In rounding mode 2'b00 (nearest), a value exactly halfway between two neighbours rounds to the one with an even last bit. A value above halfway rounds up.
- R3: Rounding mode 2'b01 truncates toward zero. Mode 2'b10 rounds toward plus infinity. Mode 2'b11 rounds toward minus infinity.
- R4: When the rounded biased exponent reaches 255, the overflow and inexact flags are set. In nearest mode the word is infinity of the result's sign (exponent FFh, fraction 0). In a directed mode that rounds toward zero for that sign, the word is the largest finite magnitude (7F7FFFFFh with the sign in bit 31). The word never holds exponent FFh with a nonzero fraction.
- R5: With flush off, a value below 2^-126 is delivered as a subnormal (exponent field 0, scale 2^-126, leading bit 0). 2^-149 gives 00000001h, and 2^-127 gives 00400000h.
- R6: A rounding carry out of the significand raises the exponent by one. A subnormal that rounds up to 2^-126 packs as 00800000h.
- R7: The underflow flag is set exactly when the value is below 2^-126 before rounding and the result is inexact. An exact subnormal raises no flag.
- R8: The inexact flag is set whenever any bit below the kept fraction is nonzero, on overflow, and on a flush that discards a value.
- R9: With the flush input at 1, a nonzero value below 2^-126 before rounding becomes a zero of the same sign, with underflow and inexact set. Normal results do not change.
- R10: The flag output is {invalid, divide-by-zero, overflow, underflow, inexact}, from bit 4 down to bit 0. Bits 4 and 3 copy `in_nv` and `in_dz` of the same transfer.
- R11: A transfer is accepted when `in_valid` and `in_ready` are both high, and it appears at the output on the next cycle. While `out_valid` is high and `out_ready` is low, `in_ready` is low and the output word and flags hold.
- R12: A significand of zero packs as an exact zero of the given sign with no rounding flags, whatever the exponent and mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input transfer offered |
| in_ready | output | 1 | Block can take an input |
| in_sign | input | 1 | Sign of the value |
| in_exp | input | EXP_W | Signed unbiased exponent |
| in_sig | input | SIG_W | Significand, binary point after top bit, low bits guard/sticky |
| in_nv | input | 1 | Invalid flag to pass through |
| in_dz | input | 1 | Divide-by-zero flag to pass through |
| rnd_mode | input | 2 | 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf |
| flush_en | input | 1 | Flush tiny results to signed zero |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_word | output | 32 | Packed single-precision result |
| out_flags | output | 5 | {invalid, divzero, overflow, underflow, inexact} |

## Verification
All decisions are made in one combinational stage, so a wrong internal choice shows in the word captured on the cycle right after the transfer. A wrong leading-zero count or exponent bias shifts the exponent field. A misjudged tiny test shows as a normal encoding where a subnormal belongs, or as a missing underflow flag. A wrong rounding increment changes the last fraction bit or misses the carry into the exponent. The directed cases sit at the edges where these faults become visible: exact ties, the largest finite value, the subnormal-to-normal boundary, and values at half the smallest subnormal.

// File: rtl/binary32_round_pack.sv
module binary32_round_pack #(
  parameter int SIG_W = 28,
  parameter int EXP_W = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic                    in_sign,
  input  logic signed [EXP_W-1:0] in_exp,
  input  logic [SIG_W-1:0]        in_sig,
  input  logic                    in_nv,
  input  logic                    in_dz,
  input  logic [1:0]              rnd_mode,
  input  logic                    flush_en,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [31:0]             out_word,
  output logic [4:0]              out_flags
);
  localparam int LZW = $clog2(SIG_W + 1);
  localparam int BW  = EXP_W + 3;

  logic [LZW-1:0]        lzc, sh;
  logic [SIG_W-1:0]      norm, shifted, pre;
  logic signed [BW-1:0]  be, shw, exp_n;
  logic                  tiny, lost, grd, stk, inexact, inc, ovf, to_inf, is_zero;
  logic [23:0]           mant;
  logic [24:0]           rnd;
  logic [22:0]           frac_n;
  logic [31:0]           word_c;
  logic [2:0]            fl_c;

  always_comb begin
    lzc = LZW'(SIG_W);
    for (int i = 0; i < SIG_W; i++)
      if (in_sig[i]) lzc = LZW'(SIG_W - 1 - i);
  end

  assign is_zero = (in_sig == '0);
  assign norm    = in_sig << lzc;
  assign be      = BW'(in_exp) - BW'(lzc) + BW'(127);
  assign tiny    = (be < 1);
  assign shw     = BW'(1) - be;
  assign sh      = (shw > SIG_W) ? LZW'(SIG_W) : shw[LZW-1:0];
  assign shifted = norm >> sh;
  assign lost    = |(norm & ~({SIG_W{1'b1}} << sh));
  assign pre     = tiny ? shifted : norm;

  assign mant    = pre[SIG_W-1 -: 24];
  assign grd     = pre[SIG_W-25];
  assign stk     = (|pre[SIG_W-26:0]) | (tiny & lost);
  assign inexact = grd | stk;

  always_comb begin
    case (rnd_mode)
      2'b00:   inc = grd & (stk | mant[0]);
      2'b01:   inc = 1'b0;
      2'b10:   inc = ~in_sign & inexact;
      default: inc = in_sign & inexact;
    endcase
  end

  assign rnd    = {1'b0, mant} + 25'(inc);
  assign exp_n  = be + BW'(rnd[24]);
  assign frac_n = rnd[24] ? rnd[23:1] : rnd[22:0];
  assign ovf    = ~tiny & (exp_n >= 255);
  assign to_inf = (rnd_mode == 2'b00) | (rnd_mode == 2'b10 & ~in_sign) |
                  (rnd_mode == 2'b11 & in_sign);

  always_comb begin
    word_c = {in_sign, 31'b0};
    fl_c   = 3'b000;
    if (is_zero) begin
      word_c = {in_sign, 31'b0};
    end else if (tiny && flush_en) begin
      fl_c   = 3'b011;
    end else if (ovf) begin
      word_c = to_inf ? {in_sign, 8'hFF, 23'h0} : {in_sign, 8'hFE, 23'h7FFFFF};
      fl_c   = 3'b101;
    end else if (tiny) begin
      word_c = {in_sign, 7'b0, rnd[23], rnd[22:0]};
      fl_c   = {1'b0, inexact, inexact};
    end else begin
      word_c = {in_sign, exp_n[7:0], frac_n};
      fl_c   = {2'b00, inexact};
    end
  end

  assign in_ready = ~out_valid | out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
      out_flags <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_word  <= word_c;
        out_flags <= {in_nv, in_dz, fl_c};
      end
    end
  end

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_word) && $stable(out_flags));

  p_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_flags[4:3] == $past({in_nv, in_dz}));

  p_no_nan_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_word[30:23] == 8'hFF |-> out_word[22:0] == 23'h0 && out_flags[2]);

  p_uf_tiny_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_flags[1] |-> out_flags[0] && out_word[30:24] == 7'h0);

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_flags[2] |-> out_flags[0]);
endmodule

// File: tb/tb_binary32_round_pack.sv
module tb_binary32_round_pack;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_sign = 0, in_nv = 0, in_dz = 0, flush_en = 0, out_ready = 1;
  logic signed [9:0] in_exp = '0;
  logic [27:0] in_sig = '0;
  logic [1:0]  rnd_mode = 2'b00;
  logic        in_ready, out_valid;
  logic [31:0] out_word;
  logic [4:0]  out_flags;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  binary32_round_pack dut (.*);

  task automatic chk(string tag, logic [36:0] act, logic [36:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(string tag, logic s, int e, logic [27:0] g, logic [1:0] m,
                     logic fz, logic [31:0] ew, logic [4:0] ef);
    @(negedge clk);
    in_sign = s; in_exp = 10'(e); in_sig = g; rnd_mode = m; flush_en = fz; in_valid = 1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 0;
    chk(tag, {out_valid, out_word, out_flags}, {1'b1, ew, ef});
  endtask

  task automatic t_reset();
    chk("R11 reset", {31'b0, out_valid, in_ready, out_word[3:0]}, {31'b0, 1'b0, 1'b1, 4'h0});
  endtask

  task automatic t_pack();
    run("R1 one",      0, 0, 28'h8000000, 2'b00, 0, 32'h3F800000, 5'h00);
    run("R1 normalize", 0, 1, 28'h4000000, 2'b00, 0, 32'h3F800000, 5'h00);
    run("R1 neg two",   1, 1, 28'h8000000, 2'b00, 0, 32'hC0000000, 5'h00);
  endtask

  task automatic t_nearest();
    run("R2 tie even",  0, 0, 28'h8000008, 2'b00, 0, 32'h3F800000, 5'h01);
    run("R2 tie odd",   0, 0, 28'h8000018, 2'b00, 0, 32'h3F800002, 5'h01);
    run("R2 above half", 0, 0, 28'h8000009, 2'b00, 0, 32'h3F800001, 5'h01);
  endtask

  task automatic t_directed();
    run("R3 rtz",      0, 0, 28'h8000001, 2'b01, 0, 32'h3F800000, 5'h01);
    run("R3 up pos",   0, 0, 28'h8000001, 2'b10, 0, 32'h3F800001, 5'h01);
    run("R3 down pos", 0, 0, 28'h8000001, 2'b11, 0, 32'h3F800000, 5'h01);
    run("R3 up neg",   1, 0, 28'h8000001, 2'b10, 0, 32'hBF800000, 5'h01);
    run("R3 down neg", 1, 0, 28'h8000001, 2'b11, 0, 32'hBF800001, 5'h01);
  endtask

  task automatic t_overflow();
    run("R4 rne inf",      0, 128, 28'h8000000, 2'b00, 0, 32'h7F800000, 5'h05);
    run("R4 rtz max",      0, 128, 28'h8000000, 2'b01, 0, 32'h7F7FFFFF, 5'h05);
    run("R4 down pos max", 0, 128, 28'h8000000, 2'b11, 0, 32'h7F7FFFFF, 5'h05);
    run("R4 up neg max",   1, 128, 28'h8000000, 2'b10, 0, 32'hFF7FFFFF, 5'h05);
    run("R4 down neg inf", 1, 128, 28'h8000000, 2'b11, 0, 32'hFF800000, 5'h05);
    run("R4 carry inf",    0, 127, 28'hFFFFFF8, 2'b00, 0, 32'h7F800000, 5'h05);
    run("R4 exact max",    0, 127, 28'hFFFFFF0, 2'b00, 0, 32'h7F7FFFFF, 5'h00);
  endtask

  task automatic t_subnormal();
    run("R5 min sub",  0, -149, 28'h8000000, 2'b00, 0, 32'h00000001, 5'h00);
    run("R5 half min", 0, -127, 28'h8000000, 2'b00, 0, 32'h00400000, 5'h00);
    run("R5 min norm", 0, -126, 28'h8000000, 2'b00, 0, 32'h00800000, 5'h00);
  endtask

  task automatic t_carry();
    run("R6 sub to norm", 0, -127, 28'hFFFFFF8, 2'b00, 0, 32'h00800000, 5'h03);
    run("R6 norm carry",  0, 0,    28'hFFFFFF8, 2'b00, 0, 32'h40000000, 5'h01);
  endtask

  task automatic t_underflow();
    run("R7 half tie zero", 0, -150, 28'h8000000, 2'b00, 0, 32'h00000000, 5'h03);
    run("R7 round to min",  0, -150, 28'hC000000, 2'b00, 0, 32'h00000001, 5'h03);
    run("R8 sub inexact up", 1, -150, 28'h8000000, 2'b11, 0, 32'h80000001, 5'h03);
  endtask

  task automatic t_flush();
    run("R9 flush pos",  0, -127, 28'h8000000, 2'b00, 1, 32'h00000000, 5'h03);
    run("R9 flush neg",  1, -149, 28'h8000000, 2'b00, 1, 32'h80000000, 5'h03);
    run("R9 normal kept", 0, -126, 28'h8000000, 2'b00, 1, 32'h00800000, 5'h00);
  endtask

  task automatic t_pass();
    @(negedge clk); in_nv = 1; in_dz = 1;
    run("R10 pass",  0, 0, 28'h8000000, 2'b00, 0, 32'h3F800000, 5'h18);
    @(negedge clk); in_nv = 0; in_dz = 1;
    run("R10 dz only", 0, 0, 28'h8000000, 2'b00, 0, 32'h3F800000, 5'h08);
    @(negedge clk); in_nv = 0; in_dz = 0;
  endtask

  task automatic t_zero();
    run("R12 neg zero", 1, 100, 28'h0, 2'b10, 0, 32'h80000000, 5'h00);
    run("R12 pos zero", 0, -300, 28'h0, 2'b00, 1, 32'h00000000, 5'h00);
  endtask

  task automatic t_stall();
    @(negedge clk);
    out_ready = 0;
    in_sign = 0; in_exp = 10'sd0; in_sig = 28'h8000000; rnd_mode = 2'b00; flush_en = 0; in_valid = 1;
    @(posedge clk);
    @(negedge clk);
    in_exp = 10'sd1;
    chk("R11 stall ready low", {36'b0, in_ready}, 37'b0);
    chk("R11 first held", {out_valid, out_word, out_flags}, {1'b1, 32'h3F800000, 5'h00});
    @(posedge clk);
    @(negedge clk);
    chk("R11 still held", {out_valid, out_word, out_flags}, {1'b1, 32'h3F800000, 5'h00});
    out_ready = 1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 0;
    chk("R11 second out", {out_valid, out_word, out_flags}, {1'b1, 32'h40000000, 5'h00});
    @(posedge clk);
    @(negedge clk);
    chk("R11 drained", {36'b0, out_valid}, 37'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_pack();
    t_nearest();
    t_directed();
    t_overflow();
    t_subnormal();
    t_carry();
    t_underflow();
    t_flush();
    t_pass();
    t_zero();
    t_stall();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule